// File: doc/BRIEF.md
# RAS/CAS Strobe Selector

This block turns a bank number and a set of per-byte column-strobe enables into four active-low row strobes and four active-low column strobes for a dynamic RAM array. A three-bit mapping field, which may change at run time, picks how the bank bits reach the strobes. One mapping drives a pair of row and column lines per bank half. One drives a single row line with every column line eligible. One drives a matching single row/column line. During an access the row strobe follows the access-active input. The column strobes are further gated by the column phase and by their own byte enable.

During a refresh cycle the access path is overridden and every column strobe stays high. The row strobes go low either all together or staggered, one group per clock edge, to spread the supply current. In the pair mapping a group is two lines; in every other mapping it is one line. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `strobe_selector`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises with idle inputs, every bit of `ras_n` and `cas_n` is 1.
- R2: With `map_mode` = 3'b101 and an access active, `bank[1]`=0 drives `ras_n` bits 0 and 1 low and `bank[1]`=1 drives bits 2 and 3 low; `bank[0]` has no effect; the column candidates are the same two lines.
- R3: With `map_mode` = 3'b110 and an access active, only `ras_n[bank]` goes low and all four column lines are candidates.
- R4: With `map_mode` = 3'b111, or any code other than 3'b101 and 3'b110, only `ras_n[bank]` and `cas_n[bank]` are candidates.
- R5: `cas_n[n]` goes low only if `byte_en[n]` is 1 (active-high enable), in every mapping.
- R6: Column strobes go low only while `cas_phase` and `acc_active` are both 1; the row strobe goes low from the first access cycle; with neither access nor refresh active all outputs are 1.
- R7: With `stagger_en`=0, refresh drives all four `ras_n` bits low together from the first refresh edge and returns them all to 1 together after `rfsh_active` falls.
- R8: With `stagger_en`=1, one more group of row strobes goes low at each refresh edge in ascending line order (single lines, or pairs 0–1 then 2–3 in mapping 3'b101), and no row strobe rises while refresh lasts.
- R9: Refresh takes priority: while `rfsh_active` is 1 all `cas_n` bits are 1 and the access inputs have no effect on `ras_n`.
- R10: Each output updates at the rising edge after its inputs are applied, one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank | input | 2 | Bank select bits |
| byte_en | input | 4 | Per-byte column strobe enables, active high |
| map_mode | input | 3 | Strobe mapping code |
| stagger_en | input | 1 | 1 staggers refresh row strobes |
| acc_active | input | 1 | Access in progress |
| cas_phase | input | 1 | Column phase of the access |
| rfsh_active | input | 1 | Refresh in progress |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 4 | Column strobes, active low |

## Verification
A refresh and an access can be requested in the same cycle. The bench provokes this by holding `acc_active`, `cas_phase` and all byte enables high while it raises `rfsh_active`, both in flat and in staggered refresh. It judges the result by expecting the refresh row pattern with every column strobe high, and then the access pattern at the first edge after refresh ends.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

   localparam int MAP_W = 3;

   localparam logic [MAP_W-1:0] MAP_PAIR     = 3'b101;
   localparam logic [MAP_W-1:0] MAP_ROW_ONLY = 3'b110;

   typedef enum logic [1:0] {
      KIND_PAIR,
      KIND_ROW_ONLY,
      KIND_SINGLE
   } map_kind_e;

   function automatic map_kind_e classify_map(input logic [MAP_W-1:0] code);
      case (code)
         MAP_PAIR:     return KIND_PAIR;
         MAP_ROW_ONLY: return KIND_ROW_ONLY;
         default:      return KIND_SINGLE;
      endcase
   endfunction

endpackage

// File: rtl/strobe_bank_decode.sv
module strobe_bank_decode
   import strobe_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int BANK_W = 2
) (
   input  logic [BANK_W-1:0] bank,
   input  map_kind_e         kind,
   output logic [LINES-1:0]  row_sel,
   output logic [LINES-1:0]  col_cand
);

   localparam int HALF = LINES / 2;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      localparam bit UPPER = (i >= HALF);
      logic hit_single;
      logic hit_pair;

      assign hit_single = (bank == BANK_W'(i));
      assign hit_pair   = (bank[BANK_W-1] == UPPER);

      always_comb begin
         unique case (kind)
            KIND_PAIR: begin
               row_sel[i]  = hit_pair;
               col_cand[i] = hit_pair;
            end
            KIND_ROW_ONLY: begin
               row_sel[i]  = hit_single;
               col_cand[i] = 1'b1;
            end
            default: begin
               row_sel[i]  = hit_single;
               col_cand[i] = hit_single;
            end
         endcase
      end
   end

endmodule

// File: rtl/strobe_rfsh_stagger.sv
module strobe_rfsh_stagger
   import strobe_pkg::*;
#(
   parameter int LINES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rfsh_active,
   input  logic             stagger_en,
   input  map_kind_e        kind,
   output logic [LINES-1:0] row_mask
);

   localparam int                CNT_W = $clog2(LINES);
   localparam int                HALF  = LINES / 2;
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LINES - 1);

   logic [CNT_W-1:0] step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (!rfsh_active) begin
         step <= '0;
      end else if (step != LAST) begin
         step <= step + 1'b1;
      end
   end

   for (genvar i = 0; i < LINES; i++) begin : g_mask
      localparam logic [CNT_W-1:0] GRP_ONE  = CNT_W'(i);
      localparam logic [CNT_W-1:0] GRP_PAIR = CNT_W'(i / HALF);
      logic reached;

      assign reached     = (kind == KIND_PAIR) ? (GRP_PAIR <= step) : (GRP_ONE <= step);
      assign row_mask[i] = !stagger_en || reached;
   end

endmodule

// File: rtl/strobe_out_reg.sv
module strobe_out_reg #(
   parameter int LINES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rfsh_active,
   input  logic             acc_active,
   input  logic             cas_phase,
   input  logic [LINES-1:0] row_mask,
   input  logic [LINES-1:0] row_sel,
   input  logic [LINES-1:0] col_cand,
   input  logic [LINES-1:0] byte_en,
   output logic [LINES-1:0] ras_n,
   output logic [LINES-1:0] cas_n
);

   logic [LINES-1:0] ras_next;
   logic [LINES-1:0] cas_next;

   always_comb begin
      ras_next = '0;
      cas_next = '0;
      if (rfsh_active) begin
         ras_next = row_mask;
      end else if (acc_active) begin
         ras_next = row_sel;
         cas_next = col_cand & byte_en & {LINES{cas_phase}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_n <= '1;
         cas_n <= '1;
      end else begin
         ras_n <= ~ras_next;
         cas_n <= ~cas_next;
      end
   end

endmodule

// File: rtl/strobe_selector.sv
module strobe_selector
   import strobe_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [LINES-1:0]  byte_en,
   input  logic [MAP_W-1:0]  map_mode,
   input  logic              stagger_en,
   input  logic              acc_active,
   input  logic              cas_phase,
   input  logic              rfsh_active,
   output logic [LINES-1:0]  ras_n,
   output logic [LINES-1:0]  cas_n
);

   if (LINES != (1 << BANK_W)) begin : g_bad_lines
      $error("strobe_selector: LINES must equal 2**BANK_W");
   end
   if (LINES < 2) begin : g_bad_min
      $error("strobe_selector: LINES must be at least 2");
   end

   map_kind_e        kind;
   logic [LINES-1:0] row_sel;
   logic [LINES-1:0] col_cand;
   logic [LINES-1:0] row_mask;

   assign kind = classify_map(map_mode);

   strobe_bank_decode #(.LINES(LINES), .BANK_W(BANK_W)) u_decode (
      .bank     (bank),
      .kind     (kind),
      .row_sel  (row_sel),
      .col_cand (col_cand)
   );

   strobe_rfsh_stagger #(.LINES(LINES)) u_stagger (
      .clk         (clk),
      .rst_n       (rst_n),
      .rfsh_active (rfsh_active),
      .stagger_en  (stagger_en),
      .kind        (kind),
      .row_mask    (row_mask)
   );

   strobe_out_reg #(.LINES(LINES)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .rfsh_active (rfsh_active),
      .acc_active  (acc_active),
      .cas_phase   (cas_phase),
      .row_mask    (row_mask),
      .row_sel     (row_sel),
      .col_cand    (col_cand),
      .byte_en     (byte_en),
      .ras_n       (ras_n),
      .cas_n       (cas_n)
   );

endmodule

// File: rtl/strobe_selector_chk.sv
module strobe_selector_chk #(
   parameter int LINES  = 4,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BANK_W-1:0] bank,
   input logic [LINES-1:0]  byte_en,
   input logic [2:0]        map_mode,
   input logic              stagger_en,
   input logic              acc_active,
   input logic              cas_phase,
   input logic              rfsh_active,
   input logic [LINES-1:0]  ras_n,
   input logic [LINES-1:0]  cas_n
);

   AST_CAS_BYTE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((~cas_n) & ~$past(byte_en)) == '0); // R5

   AST_CAS_PHASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~cas_n)) |-> $past(cas_phase && acc_active && !rfsh_active)); // R6

   AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!acc_active && !rfsh_active) |-> ((&ras_n) && (&cas_n))); // R6

   AST_RFSH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rfsh_active) |-> (&cas_n)); // R9

   AST_RFSH_FLAT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rfsh_active && !stagger_en) |-> (ras_n == '0)); // R7

   AST_STAGGER_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rfsh_active) && $past(rfsh_active, 2)) |-> ((ras_n & ~$past(ras_n)) == '0)); // R8

   AST_PAIR_TWO_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_active && !rfsh_active && map_mode == 3'b101) |-> ($countones(~ras_n) == LINES / 2)); // R2

   AST_ROW_ONLY_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_active && !rfsh_active && map_mode == 3'b110) |-> ($countones(~ras_n) == 1)); // R3

endmodule

bind strobe_selector strobe_selector_chk #(.LINES(LINES), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/strobe_selector_test.sv
module strobe_selector_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bank = '0;
   logic [3:0] byte_en = '0;
   logic [2:0] map_mode = '0;
   logic       stagger_en = 1'b0;
   logic       acc_active = 1'b0;
   logic       cas_phase = 1'b0;
   logic       rfsh_active = 1'b0;
   logic [3:0] ras_n;
   logic [3:0] cas_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] ras;
      logic [3:0] cas;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   strobe_selector uut (
      .clk(clk), .rst_n(rst_n), .bank(bank), .byte_en(byte_en),
      .map_mode(map_mode), .stagger_en(stagger_en), .acc_active(acc_active),
      .cas_phase(cas_phase), .rfsh_active(rfsh_active),
      .ras_n(ras_n), .cas_n(cas_n)
   );

   task automatic compare(input logic [3:0] er, input logic [3:0] ec, input string tag);
      n_cmp++;
      if (ras_n !== er || cas_n !== ec) begin
         n_bad++;
         $display("FAIL %s: ras_n=%b cas_n=%b expected ras_n=%b cas_n=%b", tag, ras_n, cas_n, er, ec);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the expected registered result
   task automatic step(input logic [2:0] md, input logic [1:0] bk, input logic [3:0] en,
                       input logic stg, input logic acc, input logic cph, input logic rf,
                       input logic [3:0] er, input logic [3:0] ec, input string tag);
      @(negedge clk);
      map_mode = md; bank = bk; byte_en = en; stagger_en = stg;
      acc_active = acc; cas_phase = cph; rfsh_active = rf;
      sb.push_back('{er, ec, tag});
   endtask

   // monitor: one register stage, so results are judged just after the next rising edge
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         compare(e.ras, e.cas, e.tag);
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #20000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(4'b1111, 4'b1111, "R1 in reset");
      rst_n = 1'b1;
      step(3'b111, 2'd0, 4'h0, 0, 0, 0, 0, 4'b1111, 4'b1111, "R1 after reset");

      // R2 pair mapping, bank bit 0 ignored
      step(3'b101, 2'd1, 4'hF, 0, 1, 0, 0, 4'b1100, 4'b1111, "R6 row before column phase");
      step(3'b101, 2'd1, 4'hF, 0, 1, 1, 0, 4'b1100, 4'b1100, "R2 lower pair");
      step(3'b101, 2'd0, 4'hF, 0, 1, 1, 0, 4'b1100, 4'b1100, "R2 bank0 ignored");
      step(3'b101, 2'd2, 4'hF, 0, 1, 1, 0, 4'b0011, 4'b0011, "R2 upper pair");
      step(3'b101, 2'd3, 4'b1011, 0, 1, 1, 0, 4'b0011, 4'b0111, "R5 pair byte gate");

      // R3 single row, all columns
      step(3'b110, 2'd2, 4'hF, 0, 1, 1, 0, 4'b1011, 4'b0000, "R3 row only, all columns");
      step(3'b110, 2'd2, 4'b0101, 0, 1, 1, 0, 4'b1011, 4'b1010, "R5 byte enables");

      // R4 matching single
      step(3'b111, 2'd3, 4'hF, 0, 1, 1, 0, 4'b0111, 4'b0111, "R4 single pair");
      step(3'b111, 2'd3, 4'b0111, 0, 1, 1, 0, 4'b0111, 4'b1111, "R5 disabled byte");
      step(3'b000, 2'd1, 4'hF, 0, 1, 1, 0, 4'b1101, 4'b1101, "R4 undefined code");
      step(3'b100, 2'd2, 4'hF, 0, 1, 1, 0, 4'b1011, 4'b1011, "R4 undefined code 100");
      step(3'b111, 2'd1, 4'hF, 0, 1, 0, 0, 4'b1101, 4'b1111, "R6 column phase low");
      step(3'b111, 2'd1, 4'hF, 0, 0, 1, 0, 4'b1111, 4'b1111, "R6 idle");

      // R7 flat refresh overlapping an access (R9)
      step(3'b111, 2'd0, 4'hF, 0, 1, 1, 1, 4'b0000, 4'b1111, "R7 flat refresh");
      step(3'b111, 2'd0, 4'hF, 0, 1, 1, 1, 4'b0000, 4'b1111, "R9 access ignored in refresh");
      step(3'b111, 2'd0, 4'hF, 0, 1, 1, 0, 4'b1110, 4'b1110, "R10 access after refresh");
      step(3'b111, 2'd0, 4'h0, 0, 0, 0, 0, 4'b1111, 4'b1111, "R7 all negate");

      // R8 staggered, single lines
      step(3'b111, 2'd2, 4'hF, 1, 1, 1, 1, 4'b1110, 4'b1111, "R8 stagger step 0");
      step(3'b111, 2'd2, 4'hF, 1, 1, 1, 1, 4'b1100, 4'b1111, "R8 stagger step 1");
      step(3'b111, 2'd2, 4'hF, 1, 1, 1, 1, 4'b1000, 4'b1111, "R8 stagger step 2");
      step(3'b111, 2'd2, 4'hF, 1, 1, 1, 1, 4'b0000, 4'b1111, "R8 stagger step 3");
      step(3'b111, 2'd2, 4'hF, 1, 1, 1, 1, 4'b0000, 4'b1111, "R8 stagger hold");
      step(3'b111, 2'd2, 4'h0, 1, 0, 0, 0, 4'b1111, 4'b1111, "R8 stagger end");

      // R8 staggered, pairs
      step(3'b101, 2'd0, 4'h0, 1, 0, 0, 1, 4'b1100, 4'b1111, "R8 pair step 0");
      step(3'b101, 2'd0, 4'h0, 1, 0, 0, 1, 4'b0000, 4'b1111, "R8 pair step 1");
      step(3'b101, 2'd0, 4'h0, 1, 0, 0, 1, 4'b0000, 4'b1111, "R8 pair hold");
      step(3'b101, 2'd3, 4'hF, 1, 1, 1, 0, 4'b0011, 4'b0011, "R9 access resumes");
      step(3'b111, 2'd0, 4'h0, 0, 0, 0, 0, 4'b1111, 4'b1111, "R6 idle end");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule